// File: doc/BRIEF.md
# Completion Header Checker

This block sits on the receive side of a transaction-layer path. It looks at every arriving completion header, checks it against a table of outstanding non-posted requests, and then forwards or drops the completion. The table is indexed directly by tag. Each entry holds the requester ID, the request kind (memory, IO, config type 0, config type 1), the direction, the length in DW, the expected byte count and the expected lower address. An entry is allocated on a request-issue strobe.

Each completion is sorted into one class under a fixed priority: unexpected first, then configuration retry, then malformed. A completion that only carries a retry status to a memory or IO request can be let through, with its status rewritten, when the retry check is disabled. The first completion of each error class is copied into a log slot. A malformed completion retires its tag through a timeout-response strobe, so the requester still gets an answer. Some checks can be switched off by fixed bits of a 64-bit diagnostic word.

Top module: `cpl_hdr_checker`

## Requirements
- R1: After reset, `fwd_vld`, `err_vld`, `tmo_vld` and every `log_vld` bit are 0, and no tag is outstanding, so any completion is classed as unexpected.
- R2: A completion whose tag and requester ID match an outstanding entry, and which has no defect, is forwarded with its status unchanged, raises no error, and frees the entry, so the same completion sent again is unexpected.
- R3: A completion whose tag has no outstanding entry, or whose requester ID differs from the entry, is dropped and reported with class 1 (unexpected). It leaves the entry in place, so a later correct completion for that tag is still forwarded.
- R4: A completion with the locked flag set is classed as unexpected even when every other field matches.
- R5: Status codes are SC=000, UR=001, retry=010, CA=100; all other codes are reserved. A retry completion to a config request with no other defect is dropped as class 2 (retry) and keeps the entry. A retry completion that carries data is malformed.
- R6: Any other mismatch is class 3 (malformed): a reserved status, data present on an SC write, data absent on an SC read, data present with a non-SC status, a length that differs from the request while data is present, a wrong byte count, a wrong lower address, a non-zero TC, or a non-zero Attr. A malformed completion is dropped, frees the entry and pulses `tmo_vld` with `tmo_tag` equal to the completion tag.
- R7: A completion with data whose length exceeds the maximum payload size divided by 4 is malformed, even when it equals the request length.
- R8: Setting `diag` bit 41 disables the TC check, bit 42 the Attr check, bit 43 the byte-count check and bit 44 the lower-address check. A completion whose only defects are disabled ones passes as good.
- R9: With `diag` bit 40 set, a retry completion to a memory or IO request with no other defect is forwarded with status UR and frees the entry. It is reported as class 4 for a write request and class 5 for a read request. With bit 40 clear it is malformed. Bit 40 does not affect config requests.
- R10: The order is unexpected over retry over malformed. A mismatched requester ID wins over any other defect, and a retry completion to a config request that has any further enabled defect is malformed.
- R11: The outputs are registered. The results of a completion presented in one cycle appear in the next cycle only. `err_vld` is high for exactly one cycle for each completion that is not good.
- R12: The first completion of each error class c (1..5) is captured into bits [(c-1)*W +: W] of `log_hdr`, where W is the tag width plus 55, and `log_vld` bit c-1 is set. Later errors of that class leave the slot unchanged. A slot holds, from its top bit down: tag, requester ID (16), locked, data flag, status (3), length (10), byte count (12), lower address (7), TC (3), Attr (2).
- R13: A request strobe allocates its tag at the clock edge. When an allocation and a retirement hit the same tag on the same edge, the allocation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request-issue strobe |
| req_tag | input | TAG_W | Tag of the issued request |
| req_rid | input | 16 | Requester ID of the request |
| req_kind | input | 2 | 0 memory, 1 IO, 2 config type 0, 3 config type 1 |
| req_wr | input | 1 | 1 for a write request |
| req_len | input | 10 | Request length in DW |
| req_bcnt | input | 12 | Expected completion byte count |
| req_laddr | input | 7 | Expected completion lower address |
| cpl_vld | input | 1 | Completion header valid |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_rid | input | 16 | Completion requester ID |
| cpl_locked | input | 1 | Completion is of the locked type |
| cpl_data | input | 1 | Completion carries data |
| cpl_status | input | 3 | Completion status |
| cpl_len | input | 10 | Completion length in DW |
| cpl_bcnt | input | 12 | Completion byte count |
| cpl_laddr | input | 7 | Completion lower address |
| cpl_tc | input | 3 | Completion traffic class |
| cpl_attr | input | 2 | Completion attributes |
| diag | input | DIAG_W | Diagnostic word with check-disable bits 40..44 |
| fwd_vld | output | 1 | Completion forwarded |
| fwd_tag | output | TAG_W | Tag of the forwarded completion |
| fwd_status | output | 3 | Status of the forwarded completion, after any rewrite |
| err_vld | output | 1 | One-cycle error pulse |
| err_cls | output | 3 | Error class 1..5 |
| tmo_vld | output | 1 | Timeout response requested for a malformed completion |
| tmo_tag | output | TAG_W | Tag to answer with the timeout response |
| log_vld | output | 5 | Per-class log slot filled |
| log_hdr | output | 5*(TAG_W+55) | Captured headers, one slot per class |

## Verification
The bench builds the block with TAG_W=4 and MAX_PAYLOAD_B=64. The table then has 16 entries, so random traffic often revisits a tag, and both retired and still-outstanding tags get hit. The length limit falls to 16 DW, so a legal-looking request of 20 DW reaches the payload-size rule with small numbers. The random phase draws the diagnostic bits as well, so disabled and enabled checks both meet every kind of defect.

// File: rtl/cpl_chk_pkg.sv
`timescale 1ns/1ps
package cpl_chk_pkg;
    localparam int RID_W = 16;
    localparam int LEN_W = 10;
    localparam int BC_W  = 12;
    localparam int LA_W  = 7;
    localparam int NUM_CLS = 5;

    localparam int DG_CRS  = 40;
    localparam int DG_TC   = 41;
    localparam int DG_ATTR = 42;
    localparam int DG_BCNT = 43;
    localparam int DG_LADR = 44;

    localparam logic [2:0] ST_SC  = 3'b000;
    localparam logic [2:0] ST_UR  = 3'b001;
    localparam logic [2:0] ST_CRS = 3'b010;
    localparam logic [2:0] ST_CA  = 3'b100;

    typedef enum logic [1:0] {K_MEM = 2'd0, K_IO = 2'd1, K_CFG0 = 2'd2, K_CFG1 = 2'd3} req_kind_e;

    typedef enum logic [2:0] {
        C_GOOD  = 3'd0,
        C_UNEXP = 3'd1,
        C_RETRY = 3'd2,
        C_MALF  = 3'd3,
        C_WUC   = 3'd4,
        C_RUC   = 3'd5
    } cls_e;

    typedef struct packed {
        logic              vld;
        logic [RID_W-1:0]  rid;
        req_kind_e         kind;
        logic              wr;
        logic [LEN_W-1:0]  len;
        logic [BC_W-1:0]   bcnt;
        logic [LA_W-1:0]   laddr;
    } req_ent_t;

    typedef struct packed {
        logic [RID_W-1:0]  rid;
        logic              locked;
        logic              data;
        logic [2:0]        status;
        logic [LEN_W-1:0]  len;
        logic [BC_W-1:0]   bcnt;
        logic [LA_W-1:0]   laddr;
        logic [2:0]        tc;
        logic [1:0]        attr;
    } cpl_hdr_t;

    function automatic logic kind_is_cfg(req_kind_e k);
        return (k == K_CFG0) || (k == K_CFG1);
    endfunction

    function automatic logic status_reserved(logic [2:0] st);
        return !((st == ST_SC) || (st == ST_UR) || (st == ST_CRS) || (st == ST_CA));
    endfunction

    function automatic logic cls_retires(cls_e c);
        return (c == C_GOOD) || (c == C_MALF) || (c == C_WUC) || (c == C_RUC);
    endfunction
endpackage

// File: rtl/cpl_req_table.sv
`timescale 1ns/1ps
module cpl_req_table
    import cpl_chk_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_vld,
    input  logic [TAG_W-1:0] alloc_tag,
    input  req_ent_t         alloc_ent,
    input  logic             free_vld,
    input  logic [TAG_W-1:0] free_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output req_ent_t         rd_ent
);
    localparam int NTAGS = 1 << TAG_W;

    req_ent_t ent [NTAGS];

    for (genvar g = 0; g < NTAGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (alloc_vld && alloc_tag == TAG_W'(g)) begin
                ent[g]     <= alloc_ent;
                ent[g].vld <= 1'b1;
            end else if (free_vld && free_tag == TAG_W'(g)) begin
                ent[g].vld <= 1'b0;
            end
        end
    end

    assign rd_ent = ent[rd_tag];

    // R13
    alloc_sets_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_vld |=> ent[$past(alloc_tag)].vld);
endmodule

// File: rtl/cpl_classify.sv
`timescale 1ns/1ps
module cpl_classify
    import cpl_chk_pkg::*;
#(
    parameter int MAX_DW = 128,
    parameter int DIAG_W = 64
) (
    input  req_ent_t          ent,
    input  cpl_hdr_t          hdr,
    input  logic [DIAG_W-1:0] diag,
    output cls_e              cls
);
    logic hit, cfg, is_sc, is_crs, data_bad, len_bad;
    logic bc_bad, la_bad, tc_bad, at_bad, other;

    always_comb begin
        hit      = ent.vld && (ent.rid == hdr.rid);
        cfg      = kind_is_cfg(ent.kind);
        is_sc    = (hdr.status == ST_SC);
        is_crs   = (hdr.status == ST_CRS);
        data_bad = is_sc ? (hdr.data == ent.wr) : hdr.data;
        len_bad  = hdr.data && ((hdr.len != ent.len) || (int'(hdr.len) > MAX_DW));
        bc_bad   = (hdr.bcnt  != ent.bcnt)  && !diag[DG_BCNT];
        la_bad   = (hdr.laddr != ent.laddr) && !diag[DG_LADR];
        tc_bad   = (hdr.tc   != 3'd0) && !diag[DG_TC];
        at_bad   = (hdr.attr != 2'd0) && !diag[DG_ATTR];
        other    = status_reserved(hdr.status) | data_bad | len_bad
                 | bc_bad | la_bad | tc_bad | at_bad;

        if (!hit || hdr.locked)                   cls = C_UNEXP;
        else if (is_crs && cfg && !other)         cls = C_RETRY;
        else if (other || (is_crs && !diag[DG_CRS])) cls = C_MALF;
        else if (is_crs)                          cls = ent.wr ? C_WUC : C_RUC;
        else                                      cls = C_GOOD;
    end
endmodule

// File: rtl/cpl_err_log.sv
`timescale 1ns/1ps
module cpl_err_log
    import cpl_chk_pkg::*;
#(
    parameter int LOG_W = 63
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_vld,
    input  logic [2:0]                 cap_cls,
    input  logic [LOG_W-1:0]           cap_hdr,
    output logic [NUM_CLS-1:0]         log_vld,
    output logic [NUM_CLS*LOG_W-1:0]   log_hdr
);
    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        always_ff @(posedge clk) begin
            if (rst) begin
                log_vld[k]                  <= 1'b0;
                log_hdr[k*LOG_W +: LOG_W]   <= '0;
            end else if (cap_vld && cap_cls == 3'(k + 1) && !log_vld[k]) begin
                log_vld[k]                  <= 1'b1;
                log_hdr[k*LOG_W +: LOG_W]   <= cap_hdr;
            end
        end
    end

    // R12
    log_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((log_vld & $past(log_vld)) == $past(log_vld)));
endmodule

// File: rtl/cpl_hdr_checker.sv
`timescale 1ns/1ps
module cpl_hdr_checker
    import cpl_chk_pkg::*;
#(
    parameter int TAG_W         = 8,
    parameter int MAX_PAYLOAD_B = 512,
    parameter int DIAG_W        = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_vld,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [15:0]                  req_rid,
    input  logic [1:0]                   req_kind,
    input  logic                         req_wr,
    input  logic [9:0]                   req_len,
    input  logic [11:0]                  req_bcnt,
    input  logic [6:0]                   req_laddr,
    input  logic                         cpl_vld,
    input  logic [TAG_W-1:0]             cpl_tag,
    input  logic [15:0]                  cpl_rid,
    input  logic                         cpl_locked,
    input  logic                         cpl_data,
    input  logic [2:0]                   cpl_status,
    input  logic [9:0]                   cpl_len,
    input  logic [11:0]                  cpl_bcnt,
    input  logic [6:0]                   cpl_laddr,
    input  logic [2:0]                   cpl_tc,
    input  logic [1:0]                   cpl_attr,
    input  logic [DIAG_W-1:0]            diag,
    output logic                         fwd_vld,
    output logic [TAG_W-1:0]             fwd_tag,
    output logic [2:0]                   fwd_status,
    output logic                         err_vld,
    output logic [2:0]                   err_cls,
    output logic                         tmo_vld,
    output logic [TAG_W-1:0]             tmo_tag,
    output logic [4:0]                   log_vld,
    output logic [5*(TAG_W+55)-1:0]      log_hdr
);
    localparam int MAX_DW = MAX_PAYLOAD_B / 4;
    localparam int LOG_W  = TAG_W + $bits(cpl_hdr_t);

    cpl_hdr_t hdr;
    req_ent_t new_ent, cur_ent;
    cls_e     cls;
    logic     retire;

    always_comb begin
        hdr = '{rid: cpl_rid, locked: cpl_locked, data: cpl_data, status: cpl_status,
                len: cpl_len, bcnt: cpl_bcnt, laddr: cpl_laddr, tc: cpl_tc, attr: cpl_attr};
        new_ent = '{vld: 1'b1, rid: req_rid, kind: req_kind_e'(req_kind), wr: req_wr,
                    len: req_len, bcnt: req_bcnt, laddr: req_laddr};
    end

    assign retire = cpl_vld && cls_retires(cls);

    cpl_req_table #(.TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .alloc_vld (req_vld),
        .alloc_tag (req_tag),
        .alloc_ent (new_ent),
        .free_vld  (retire),
        .free_tag  (cpl_tag),
        .rd_tag    (cpl_tag),
        .rd_ent    (cur_ent)
    );

    cpl_classify #(.MAX_DW(MAX_DW), .DIAG_W(DIAG_W)) u_cls (
        .ent  (cur_ent),
        .hdr  (hdr),
        .diag (diag),
        .cls  (cls)
    );

    cpl_err_log #(.LOG_W(LOG_W)) u_log (
        .clk     (clk),
        .rst     (rst),
        .cap_vld (cpl_vld && cls != C_GOOD),
        .cap_cls (cls),
        .cap_hdr ({cpl_tag, hdr}),
        .log_vld (log_vld),
        .log_hdr (log_hdr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_vld    <= 1'b0;
            fwd_tag    <= '0;
            fwd_status <= '0;
            err_vld    <= 1'b0;
            err_cls    <= '0;
            tmo_vld    <= 1'b0;
            tmo_tag    <= '0;
        end else begin
            fwd_vld    <= cpl_vld && (cls == C_GOOD || cls == C_WUC || cls == C_RUC);
            fwd_tag    <= cpl_tag;
            fwd_status <= (cls == C_WUC || cls == C_RUC) ? ST_UR : cpl_status;
            err_vld    <= cpl_vld && (cls != C_GOOD);
            err_cls    <= cpl_vld ? cls : C_GOOD;
            tmo_vld    <= cpl_vld && (cls == C_MALF);
            tmo_tag    <= cpl_tag;
        end
    end

    // R3
    unexp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (err_vld && err_cls == C_UNEXP) |-> !fwd_vld);

    // R6
    tmo_malf_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_vld |-> (err_vld && err_cls == C_MALF && !fwd_vld));

    // R11
    out_follows_in_chk: assert property (@(posedge clk) disable iff (rst)
        (err_vld || fwd_vld) |-> $past(cpl_vld));

    // R9
    rewrite_ur_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_vld && err_vld) |-> (fwd_status == ST_UR && (err_cls == C_WUC || err_cls == C_RUC)));
endmodule

// File: tb/cpl_hdr_checker_bench.sv
`timescale 1ns/1ps
module cpl_hdr_checker_bench;
    localparam int TAG_W  = 4;
    localparam int MAXPB  = 64;
    localparam int MAXDW  = MAXPB / 4;
    localparam int NT     = 1 << TAG_W;
    localparam int LW     = TAG_W + 55;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             req_vld = 0;
    logic [TAG_W-1:0] req_tag = 0;
    logic [15:0]      req_rid = 0;
    logic [1:0]       req_kind = 0;
    logic             req_wr = 0;
    logic [9:0]       req_len = 0;
    logic [11:0]      req_bcnt = 0;
    logic [6:0]       req_laddr = 0;
    logic             cpl_vld = 0;
    logic [TAG_W-1:0] cpl_tag = 0;
    logic [15:0]      cpl_rid = 0;
    logic             cpl_locked = 0, cpl_data = 0;
    logic [2:0]       cpl_status = 0;
    logic [9:0]       cpl_len = 0;
    logic [11:0]      cpl_bcnt = 0;
    logic [6:0]       cpl_laddr = 0;
    logic [2:0]       cpl_tc = 0;
    logic [1:0]       cpl_attr = 0;
    logic [63:0]      diag = 0;
    logic             fwd_vld, err_vld, tmo_vld;
    logic [TAG_W-1:0] fwd_tag, tmo_tag;
    logic [2:0]       fwd_status, err_cls;
    logic [4:0]       log_vld;
    logic [5*LW-1:0]  log_hdr;

    cpl_hdr_checker #(.TAG_W(TAG_W), .MAX_PAYLOAD_B(MAXPB), .DIAG_W(64)) u_cpl_hdr_checker (
        .clk(clk), .rst(rst),
        .req_vld(req_vld), .req_tag(req_tag), .req_rid(req_rid), .req_kind(req_kind),
        .req_wr(req_wr), .req_len(req_len), .req_bcnt(req_bcnt), .req_laddr(req_laddr),
        .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .cpl_rid(cpl_rid), .cpl_locked(cpl_locked),
        .cpl_data(cpl_data), .cpl_status(cpl_status), .cpl_len(cpl_len), .cpl_bcnt(cpl_bcnt),
        .cpl_laddr(cpl_laddr), .cpl_tc(cpl_tc), .cpl_attr(cpl_attr), .diag(diag),
        .fwd_vld(fwd_vld), .fwd_tag(fwd_tag), .fwd_status(fwd_status),
        .err_vld(err_vld), .err_cls(err_cls), .tmo_vld(tmo_vld), .tmo_tag(tmo_tag),
        .log_vld(log_vld), .log_hdr(log_hdr)
    );

    // bench model of the outstanding requests
    logic        m_vld   [NT];
    logic [15:0] m_rid   [NT];
    logic [1:0]  m_kind  [NT];
    logic        m_wr    [NT];
    logic [9:0]  m_len   [NT];
    logic [11:0] m_bcnt  [NT];
    logic [6:0]  m_laddr [NT];
    logic          e_lvld [5];
    logic [LW-1:0] e_lhdr [5];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(string rq, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic issue(int tag, int rid, int kind, bit wr, int len, int bc, int la);
        @(negedge clk);
        req_vld = 1; req_tag = TAG_W'(tag); req_rid = 16'(rid); req_kind = 2'(kind);
        req_wr = wr; req_len = 10'(len); req_bcnt = 12'(bc); req_laddr = 7'(la);
        @(negedge clk);
        req_vld = 0;
        m_vld[tag] = 1; m_rid[tag] = 16'(rid); m_kind[tag] = 2'(kind); m_wr[tag] = wr;
        m_len[tag] = 10'(len); m_bcnt[tag] = 12'(bc); m_laddr[tag] = 7'(la);
    endtask

    // set cpl_* to the correct completion for an outstanding tag
    task automatic good_cpl(int tag);
        cpl_tag = TAG_W'(tag); cpl_rid = m_rid[tag]; cpl_locked = 0;
        cpl_status = 3'b000; cpl_data = !m_wr[tag];
        cpl_len = m_wr[tag] ? 10'd0 : m_len[tag];
        cpl_bcnt = m_bcnt[tag]; cpl_laddr = m_laddr[tag]; cpl_tc = 0; cpl_attr = 0;
    endtask

    function automatic int ref_cls();
        int t = int'(cpl_tag);
        bit cfg, sc, crs, rsv, dbad, lbad, other;
        if (!m_vld[t] || m_rid[t] != cpl_rid || cpl_locked) return 1;
        cfg  = m_kind[t] >= 2;
        sc   = cpl_status == 3'b000;
        crs  = cpl_status == 3'b010;
        rsv  = !(cpl_status == 3'b000 || cpl_status == 3'b001 || cpl_status == 3'b010 || cpl_status == 3'b100);
        dbad = sc ? (cpl_data != !m_wr[t]) : cpl_data;
        lbad = cpl_data && (cpl_len != m_len[t] || int'(cpl_len) > MAXDW);
        other = rsv || dbad || lbad || (cpl_bcnt != m_bcnt[t] && !diag[43])
              || (cpl_laddr != m_laddr[t] && !diag[44]) || (cpl_tc != 0 && !diag[41])
              || (cpl_attr != 0 && !diag[42]);
        if (crs && cfg && !other) return 2;
        if (other || (crs && !cfg && !diag[40])) return 3;
        if (crs) return m_wr[t] ? 4 : 5;
        return 0;
    endfunction

    function automatic string req_of(int c);
        case (c)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R9";
        endcase
    endfunction

    // drive the completion held in cpl_*, check one cycle later
    task automatic send(string rq, int force_exp);
        int e, t;
        bit fwd;
        @(negedge clk);
        cpl_vld = 1;
        e = ref_cls();
        t = int'(cpl_tag);
        if (force_exp >= 0 && force_exp != e)
            $display("note: bench expectation override mismatch in %s", rq);
        if (rq == "") rq = req_of(e);
        if (e != 0 && !e_lvld[e-1]) begin
            e_lvld[e-1] = 1;
            e_lhdr[e-1] = {cpl_tag, cpl_rid, cpl_locked, cpl_data, cpl_status, cpl_len,
                           cpl_bcnt, cpl_laddr, cpl_tc, cpl_attr};
        end
        @(negedge clk);
        cpl_vld = 0;
        fwd = (e == 0 || e == 4 || e == 5);
        check(rq, "err_vld", err_vld, e != 0);
        if (e != 0) check(rq, "err_cls", err_cls, e);
        check(rq, "fwd_vld", fwd_vld, fwd);
        if (fwd) check(rq, "fwd_status", fwd_status, (e == 0) ? cpl_status : 3'b001);
        check(rq, "tmo_vld", tmo_vld, e == 3);
        if (e == 3) check(rq, "tmo_tag", tmo_tag, t);
        if (e == 0 || e == 3 || e == 4 || e == 5) m_vld[t] = 0;
        if (force_exp >= 0) check(rq, "class", e, force_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NT; i++) m_vld[i] = 0;
        for (int i = 0; i < 5; i++) begin e_lvld[i] = 0; e_lhdr[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "fwd_vld", fwd_vld, 0);
        check("R1", "err_vld", err_vld, 0);
        check("R1", "tmo_vld", tmo_vld, 0);
        check("R1", "log_vld", log_vld, 0);
        cpl_tag = 3; cpl_rid = 16'h0100; cpl_locked = 0; cpl_data = 1; cpl_status = 0;
        cpl_len = 1; cpl_bcnt = 4; cpl_laddr = 0; cpl_tc = 0; cpl_attr = 0;
        send("R1", 1);
        // R11 pulse is one cycle
        @(negedge clk);
        check("R11", "err_vld second cycle", err_vld, 0);

        // R2 good then resend
        issue(1, 16'h0a01, 0, 0, 4, 16, 8);
        good_cpl(1); send("R2", 0);
        send("R2", 1);

        // R3 wrong rid, then good still accepted
        issue(2, 16'h0b02, 1, 1, 1, 4, 0);
        good_cpl(2); cpl_rid = 16'h0b03; send("R3", 1);
        good_cpl(2); send("R3", 0);

        // R4 locked
        issue(2, 16'h0c02, 0, 0, 2, 8, 4);
        good_cpl(2); cpl_locked = 1; send("R4", 1);
        good_cpl(2); send("R4", 0);

        // R5 config retry
        issue(5, 16'h0d05, 2, 0, 1, 4, 0);
        good_cpl(5); cpl_status = 3'b010; cpl_data = 0; cpl_len = 0; send("R5", 2);
        good_cpl(5); cpl_status = 3'b010; cpl_data = 1; send("R5", 3);

        // R6 byte count, status with data, reserved status
        issue(6, 16'h0e06, 0, 0, 3, 12, 4);
        good_cpl(6); cpl_bcnt = 13; send("R6", 3);
        issue(6, 16'h0e06, 0, 0, 3, 12, 4);
        good_cpl(6); cpl_status = 3'b001; send("R6", 3);
        issue(6, 16'h0e06, 0, 0, 3, 12, 4);
        good_cpl(6); cpl_status = 3'b111; cpl_data = 0; send("R6", 3);
        issue(7, 16'h0e07, 1, 1, 1, 4, 0);
        good_cpl(7); cpl_data = 1; cpl_len = 1; send("R6", 3);

        // R7 length over max payload
        issue(8, 16'h0f08, 0, 0, MAXDW + 4, (MAXDW + 4) * 4, 0);
        good_cpl(8); send("R7", 3);

        // R8 disabled checks
        diag = 64'd1 << 43;
        issue(9, 16'h1109, 0, 0, 2, 8, 0);
        good_cpl(9); cpl_bcnt = 9; send("R8", 0);
        diag = 64'd1 << 41;
        issue(9, 16'h1109, 0, 0, 2, 8, 0);
        good_cpl(9); cpl_tc = 3; send("R8", 0);
        diag = 64'd1 << 42;
        issue(9, 16'h1109, 0, 0, 2, 8, 0);
        good_cpl(9); cpl_attr = 2; send("R8", 0);
        diag = 64'd1 << 44;
        issue(9, 16'h1109, 0, 0, 2, 8, 0);
        good_cpl(9); cpl_laddr = 5; send("R8", 0);
        diag = 64'd1 << 43;
        issue(9, 16'h1109, 0, 0, 2, 8, 0);
        good_cpl(9); cpl_tc = 1; send("R8", 3);

        // R9 retry status rewritten
        diag = 64'd1 << 40;
        issue(10, 16'h120a, 1, 1, 1, 4, 0);
        good_cpl(10); cpl_status = 3'b010; send("R9", 4);
        issue(11, 16'h120b, 0, 0, 2, 8, 0);
        good_cpl(11); cpl_status = 3'b010; cpl_data = 0; send("R9", 5);
        diag = 0;
        issue(11, 16'h120b, 0, 0, 2, 8, 0);
        good_cpl(11); cpl_status = 3'b010; cpl_data = 0; send("R9", 3);

        // R10 priority
        issue(12, 16'h130c, 3, 0, 1, 4, 0);
        good_cpl(12); cpl_status = 3'b010; cpl_data = 0; cpl_rid = 16'h0; send("R10", 1);
        good_cpl(12); cpl_status = 3'b010; cpl_data = 0; cpl_tc = 2; send("R10", 3);

        // R13 allocation beats retirement on same edge
        issue(13, 16'h140d, 0, 0, 1, 4, 0);
        good_cpl(13);
        @(negedge clk);
        cpl_vld = 1; req_vld = 1; req_tag = 13; req_rid = 16'h150d; req_kind = 0;
        req_wr = 0; req_len = 1; req_bcnt = 4; req_laddr = 0;
        @(negedge clk);
        cpl_vld = 0; req_vld = 0;
        check("R13", "fwd_vld same edge", fwd_vld, 1);
        m_vld[13] = 1; m_rid[13] = 16'h150d;
        good_cpl(13); send("R13", 0);

        // R12 log contents so far
        check("R12", "log UC slot", log_hdr[0 +: LW], e_lhdr[0]);

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int tg = int'($urandom_range(0, NT - 1));
            diag = 0;
            for (int b = 40; b < 45; b++) diag[b] = ($urandom_range(0, 3) == 0);
            if (!m_vld[tg] && $urandom_range(0, 2) != 0) begin
                int k = int'($urandom_range(0, 3));
                int ln = int'($urandom_range(1, MAXDW));
                issue(tg, int'($urandom_range(1, 16'hffff)), k, 1'($urandom_range(0, 1)),
                      ln, ln * 4, int'($urandom_range(0, 127)));
            end else begin
                if (m_vld[tg]) good_cpl(tg);
                else begin
                    cpl_tag = TAG_W'(tg); cpl_rid = 16'($urandom); cpl_locked = 0;
                    cpl_data = 0; cpl_status = 0; cpl_len = 0; cpl_bcnt = 0;
                    cpl_laddr = 0; cpl_tc = 0; cpl_attr = 0;
                end
                case ($urandom_range(0, 11))
                    0: cpl_rid = cpl_rid ^ 16'h0001;
                    1: cpl_locked = 1;
                    2: begin cpl_status = 3'b010; cpl_data = 0; end
                    3: cpl_data = !cpl_data;
                    4: cpl_len = cpl_len + 10'd1;
                    5: cpl_bcnt = cpl_bcnt + 12'd4;
                    6: cpl_laddr = cpl_laddr ^ 7'h04;
                    7: cpl_tc = 3'($urandom_range(1, 7));
                    8: cpl_attr = 2'($urandom_range(1, 3));
                    9: begin cpl_status = 3'($urandom_range(1, 7)); cpl_data = 0; end
                    default: ;
                endcase
                send("", -1);
            end
        end

        // R12 final log state
        for (int k = 0; k < 5; k++) begin
            check("R12", "log_vld bit", log_vld[k], e_lvld[k]);
            if (e_lvld[k]) check("R12", "log slot", log_hdr[k*LW +: LW], e_lhdr[k]);
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule